// File: doc/BRIEF.md
# Paired DMA Request Multiplexer

This block sits between a set of peripheral DMA request lines and the request inputs of an eight-channel DMA engine. Channels are grouped in pairs (an even receive channel and an odd transmit channel), and each pair owns one 4-bit selector field that names the peripheral it serves. The selected peripheral request is conditioned per channel, either passed straight through (level) or captured on its rising edge and held until the channel acknowledges it (edge). Acknowledges from the channels are routed back to the peripheral that the pair selected.

When two pairs name the same peripheral, the pair with the lower index wins. It alone receives that peripheral's request and alone may drive that peripheral's acknowledge. The losing pair sees no request. The selector code 15 means "no peripheral". A channel in software request mode ignores the hardware request entirely. The selector register is loaded through a plain write port that replaces the whole register. Its value is visible on a read-back output.

Top module: `dma_req_router`

## Requirements
- R1: After reset, every selector field holds 15 (no peripheral), and `ch_req` and `periph_ack` are all zero.
- R2: Selector field k occupies `sel_wr_data[4k+3:4k]` and serves channels 2k and 2k+1. A write with `sel_wr_en` high replaces the whole register. The new value appears on `sel_rd` one cycle later and steers requests from that cycle on.
- R3: A channel with `ch_hw_mode`=1 (hardware) and `ch_edge`=0 (level) drives `ch_req` to the value its pair's selected peripheral request had one clock earlier.
- R4: With `ch_hw_mode`=1 and `ch_edge`=1 (edge), a 0-to-1 change of the selected request sets `ch_req` on the next cycle. The request then stays high while the request line remains high or falls, until a cycle with `ch_ack` high; it is low the cycle after that ack. A request line that simply stays high does not set it again.
- R5: A channel with `ch_hw_mode`=0 (software) keeps `ch_req` low whatever its peripheral request does.
- R6: A selector field whose value is 15 (or any value not below the number of peripheral lines) gives its pair no request and routes none of its acknowledges.
- R7: When several fields hold the same peripheral index, only the lowest-numbered field receives that request. Acknowledges from the higher-numbered pairs do not reach that peripheral.
- R8: `periph_ack[p]` is high one cycle after a cycle in which either channel of the pair that owns peripheral p had `ch_ack` high.
- R9: In edge mode, a rising edge that arrives in the same cycle as `ch_ack` sets the request. The new edge takes precedence over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_wr_en | input | 1 | Load the selector register |
| sel_wr_data | input | 16 | New selector register value, 4 bits per channel pair |
| periph_req | input | 15 | Peripheral DMA request lines |
| ch_hw_mode | input | 8 | Per channel: 1 = hardware request, 0 = software |
| ch_edge | input | 8 | Per channel: 1 = edge sensing, 0 = level |
| ch_ack | input | 8 | Per-channel acknowledge from the DMA engine |
| ch_req | output | 8 | Conditioned request to each channel (registered) |
| periph_ack | output | 15 | Acknowledge to each peripheral (registered) |
| sel_rd | output | 16 | Current selector register value |

## Verification
The bench builds the block with its defaults: eight channels, four selector fields of 4 bits, and fifteen peripheral lines. With these values the "no peripheral" code 15 is the only out-of-range code, and every other code names a real line, so a sweep over all fifteen indices on one pair covers the full routing mux. Four pairs are enough to set up a duplicated selection between pair 0 and pair 2 while pairs 1 and 3 stay independent. This exposes both the priority rule and the hand-over of a peripheral to the next pair once the winner is parked on code 15.

// File: rtl/dmx_pkg.sv
`timescale 1ns/1ps
package dmx_pkg;
  typedef enum logic { SENSE_LEVEL = 1'b0, SENSE_EDGE = 1'b1 } sense_e;
  typedef enum logic { REQ_SW = 1'b0, REQ_HW = 1'b1 } req_mode_e;
endpackage

// File: rtl/dmx_sel_reg.sv
`timescale 1ns/1ps
module dmx_sel_reg #(
  parameter int NUM_SEL = 4,
  parameter int SEL_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [NUM_SEL*SEL_W-1:0]   wr_data,
  output logic [NUM_SEL*SEL_W-1:0]   sel_q
);
  localparam int REG_W = NUM_SEL * SEL_W;

  // Reset parks every pair on the all-ones "no peripheral" code.
  always_ff @(posedge clk) begin
    if (rst)        sel_q <= {REG_W{1'b1}};
    else if (wr_en) sel_q <= wr_data;
  end
endmodule

// File: rtl/dmx_route.sv
`timescale 1ns/1ps
module dmx_route #(
  parameter int NUM_SEL    = 4,
  parameter int SEL_W      = 4,
  parameter int NUM_PERIPH = 15
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_SEL*SEL_W-1:0] sel_flat,
  input  logic [NUM_PERIPH-1:0]    periph_req,
  input  logic [2*NUM_SEL-1:0]     ch_ack,
  output logic [NUM_SEL-1:0]       pair_raw,
  output logic [NUM_PERIPH-1:0]    periph_ack
);
  localparam logic [SEL_W:0] PER_LIM = (SEL_W+1)'(NUM_PERIPH);

  logic [SEL_W-1:0]      sel_a [NUM_SEL];
  logic [NUM_SEL-1:0]    valid;
  logic [NUM_SEL-1:0]    win;
  logic [NUM_PERIPH-1:0] ack_nxt;

  // Field decode and priority: a field loses if a lower field holds the same code.
  always_comb begin
    for (int k = 0; k < NUM_SEL; k++) begin
      sel_a[k] = sel_flat[k*SEL_W +: SEL_W];
      valid[k] = ({1'b0, sel_a[k]} < PER_LIM);
    end
    for (int k = 0; k < NUM_SEL; k++) begin
      win[k] = valid[k];
      for (int j = 0; j < k; j++) begin
        if (valid[j] && (sel_a[j] == sel_a[k])) win[k] = 1'b0;
      end
    end
  end

  // Request mux per pair.
  always_comb begin
    for (int k = 0; k < NUM_SEL; k++) begin
      pair_raw[k] = 1'b0;
      for (int p = 0; p < NUM_PERIPH; p++) begin
        if (win[k] && (sel_a[k] == SEL_W'(p))) pair_raw[k] = periph_req[p];
      end
    end
  end

  // Acknowledge steering: only the winning pair reaches a peripheral.
  always_comb begin
    for (int p = 0; p < NUM_PERIPH; p++) begin
      ack_nxt[p] = 1'b0;
      for (int k = 0; k < NUM_SEL; k++) begin
        if (win[k] && (sel_a[k] == SEL_W'(p)))
          ack_nxt[p] = ack_nxt[p] | ch_ack[2*k] | ch_ack[2*k+1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) periph_ack <= '0;
    else     periph_ack <= ack_nxt;
  end
endmodule

// File: rtl/dmx_sense.sv
`timescale 1ns/1ps
module dmx_sense
  import dmx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic raw,
  input  logic hw_mode,
  input  logic edge_mode,
  input  logic ack,
  output logic req
);
  logic raw_d;
  logic rise;

  always_comb rise = raw & ~raw_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_d <= 1'b0;
      req   <= 1'b0;
    end else begin
      raw_d <= raw;
      if (req_mode_e'(hw_mode) != REQ_HW)
        req <= 1'b0;
      else if (sense_e'(edge_mode) == SENSE_EDGE)
        req <= rise | (req & ~ack);   // new edge beats a same-cycle clear
      else
        req <= raw;
    end
  end
endmodule

// File: rtl/dma_req_router.sv
`timescale 1ns/1ps
module dma_req_router #(
  parameter int NUM_CH     = 8,
  parameter int SEL_W      = 4,
  parameter int NUM_PERIPH = 15
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          sel_wr_en,
  input  logic [(NUM_CH/2)*SEL_W-1:0]   sel_wr_data,
  input  logic [NUM_PERIPH-1:0]         periph_req,
  input  logic [NUM_CH-1:0]             ch_hw_mode,
  input  logic [NUM_CH-1:0]             ch_edge,
  input  logic [NUM_CH-1:0]             ch_ack,
  output logic [NUM_CH-1:0]             ch_req,
  output logic [NUM_PERIPH-1:0]         periph_ack,
  output logic [(NUM_CH/2)*SEL_W-1:0]   sel_rd
);
  localparam int NUM_SEL = NUM_CH / 2;

  logic [NUM_SEL-1:0] pair_raw;

  dmx_sel_reg #(.NUM_SEL(NUM_SEL), .SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst(rst), .wr_en(sel_wr_en), .wr_data(sel_wr_data), .sel_q(sel_rd)
  );

  dmx_route #(.NUM_SEL(NUM_SEL), .SEL_W(SEL_W), .NUM_PERIPH(NUM_PERIPH)) u_route (
    .clk(clk), .rst(rst), .sel_flat(sel_rd), .periph_req(periph_req),
    .ch_ack(ch_ack), .pair_raw(pair_raw), .periph_ack(periph_ack)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dmx_sense u_sense (
      .clk(clk), .rst(rst), .raw(pair_raw[c/2]), .hw_mode(ch_hw_mode[c]),
      .edge_mode(ch_edge[c]), .ack(ch_ack[c]), .req(ch_req[c])
    );
  end
endmodule

// File: rtl/dmx_checker.sv
`timescale 1ns/1ps
module dmx_checker #(
  parameter int NUM_CH     = 8,
  parameter int SEL_W      = 4,
  parameter int NUM_PERIPH = 15
) (
  input logic                        clk,
  input logic                        rst,
  input logic [NUM_CH-1:0]           ch_hw_mode,
  input logic [NUM_CH-1:0]           ch_edge,
  input logic [NUM_CH-1:0]           ch_ack,
  input logic [NUM_CH-1:0]           ch_req,
  input logic [NUM_PERIPH-1:0]       periph_ack,
  input logic [(NUM_CH/2)*SEL_W-1:0] sel_rd
);
  localparam logic [SEL_W:0] LIM = (SEL_W+1)'(NUM_PERIPH);

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ch_req == '0) && (periph_ack == '0));

  p_ack_source_r8: assert property (@(posedge clk) disable iff (rst)
    (|periph_ack) |-> $past(|ch_ack));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    localparam int K = c / 2;

    p_sw_quiet_r5: assert property (@(posedge clk) disable iff (rst)
      !ch_hw_mode[c] |=> !ch_req[c]);

    p_edge_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (ch_req[c] && ch_edge[c] && ch_hw_mode[c] && !ch_ack[c]) |=> ch_req[c]);

    p_none_level_r6: assert property (@(posedge clk) disable iff (rst)
      (!ch_edge[c] && ({1'b0, sel_rd[K*SEL_W +: SEL_W]} >= LIM)) |=> !ch_req[c]);
  end
endmodule

bind dma_req_router dmx_checker #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .NUM_PERIPH(NUM_PERIPH)) u_chk (
  .clk(clk), .rst(rst), .ch_hw_mode(ch_hw_mode), .ch_edge(ch_edge), .ch_ack(ch_ack),
  .ch_req(ch_req), .periph_ack(periph_ack), .sel_rd(sel_rd)
);

// File: tb/sim_dma_req_router.sv
`timescale 1ns/1ps
module sim_dma_req_router;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_wr_en = 1'b0;
  logic [15:0] sel_wr_data = '0;
  logic [14:0] periph_req = '0;
  logic [7:0]  ch_hw_mode = '0, ch_edge = '0, ch_ack = '0;
  logic [7:0]  ch_req;
  logic [14:0] periph_ack;
  logic [15:0] sel_rd;

  always #2 clk = ~clk;   // 250 MHz

  dma_req_router u0 (
    .clk(clk), .rst(rst), .sel_wr_en(sel_wr_en), .sel_wr_data(sel_wr_data),
    .periph_req(periph_req), .ch_hw_mode(ch_hw_mode), .ch_edge(ch_edge), .ch_ack(ch_ack),
    .ch_req(ch_req), .periph_ack(periph_ack), .sel_rd(sel_rd)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // stimulus variables
  logic        we = 0;
  logic [15:0] wd = '0;
  logic [14:0] pr = '0;
  logic [7:0]  hw = '0, ed = '0, ak = '0;

  // reference state
  logic [3:0] m_sel [4];
  logic [7:0] m_req  = '0;
  logic [3:0] m_prev = '0;

  // scoreboard
  logic [7:0]  q_req [$];
  logic [14:0] q_ack [$];
  logic [15:0] q_sel [$];
  string       q_tag [$];

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    logic [3:0]  raw;
    logic [3:0]  win;
    logic [7:0]  nreq;
    logic [14:0] nack;
    @(negedge clk);
    sel_wr_en = we; sel_wr_data = wd; periph_req = pr;
    ch_hw_mode = hw; ch_edge = ed; ch_ack = ak;
    for (int k = 0; k < 4; k++) begin
      win[k] = (m_sel[k] < 4'd15);
      for (int j = 0; j < k; j++)
        if (m_sel[j] < 4'd15 && m_sel[j] == m_sel[k]) win[k] = 1'b0;
      raw[k] = win[k] ? pr[m_sel[k]] : 1'b0;
    end
    for (int c = 0; c < 8; c++) begin
      if (!hw[c])      nreq[c] = 1'b0;
      else if (ed[c])  nreq[c] = (raw[c/2] & ~m_prev[c/2]) | (m_req[c] & ~ak[c]);
      else             nreq[c] = raw[c/2];
    end
    nack = '0;
    for (int k = 0; k < 4; k++)
      if (win[k] && (ak[2*k] | ak[2*k+1])) nack[m_sel[k]] = 1'b1;
    m_prev = raw;
    m_req  = nreq;
    if (we) for (int k = 0; k < 4; k++) m_sel[k] = wd[4*k +: 4];
    q_req.push_back(nreq);
    q_ack.push_back(nack);
    q_sel.push_back({m_sel[3], m_sel[2], m_sel[1], m_sel[0]});
    q_tag.push_back(tag);
  endtask

  // monitor: compare one expected item per clock edge
  always begin
    @(posedge clk);
    #1;
    if (q_req.size() > 0) begin
      string t;
      t = q_tag.pop_front();
      check(t, "ch_req",     {8'h0, ch_req},     {8'h0, q_req.pop_front()});
      check(t, "periph_ack", {1'b0, periph_ack}, {1'b0, q_ack.pop_front()});
      check(t, "sel_rd",     sel_rd,             q_sel.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) m_sel[k] = 4'hF;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state, before any non-reset edge
    check("R1", "ch_req",     {8'h0, ch_req},     16'h0);
    check("R1", "periph_ack", {1'b0, periph_ack}, 16'h0);
    check("R1", "sel_rd",     sel_rd,             16'hFFFF);
    step("R1");

    // R6: all pairs parked on code 15, everything requesting
    pr = '1; hw = '1; step("R6"); step("R6");
    ak = '1; step("R6"); ak = '0;

    // R2: load pair0=5, pair1=3
    pr = '0; we = 1; wd = 16'hFF35; step("R2"); we = 0; step("R2");

    // R3: level sensing, several patterns
    pr = 15'h0020; step("R3"); step("R3");
    pr = 15'h0028; step("R3");
    pr = 15'h0008; step("R3");
    pr = 15'h0000; step("R3");
    for (int p = 0; p < 15; p++) begin
      we = 1; wd = {12'hFF3, 4'(p)}; pr = 15'(1) << p; step("R3");
      we = 0; step("R3");
      pr = '0; step("R3");
    end
    we = 1; wd = 16'hFF35; step("R2"); we = 0;

    // R5: channel 1 in software mode
    hw = 8'hFD; pr = 15'h0020; step("R5"); step("R5");
    pr = 15'h0000; step("R5"); pr = 15'h0020; step("R5");

    // R4: edge sensing on channel 1
    hw = '1; ed = 8'h02; pr = '0; step("R4"); step("R4");
    pr = 15'h0020; step("R4"); step("R4"); step("R4");
    pr = '0; step("R4");
    ak = 8'h02; step("R4"); ak = '0; step("R4");
    pr = 15'h0020; step("R4"); step("R4");
    ak = 8'h02; step("R4"); ak = '0; step("R4"); step("R4");
    // R9: rising edge together with ack
    pr = '0; step("R9");
    pr = 15'h0020; ak = 8'h02; step("R9"); ak = '0; step("R9");
    ak = 8'h02; step("R9"); ak = '0;

    // R8: acknowledge routing
    ed = '0; ak = 8'h04; step("R8"); ak = 8'h08; step("R8");
    ak = 8'h01; step("R8"); ak = 8'h03; step("R8"); ak = '0; step("R8");

    // R7: pair2 duplicates pair0 (peripheral 5)
    we = 1; wd = 16'hF535; step("R7"); we = 0;
    pr = 15'h0020; step("R7"); step("R7");
    ak = 8'h10; step("R7"); ak = 8'h20; step("R7");
    ak = 8'h01; step("R7"); ak = '0; step("R7");

    // R6 / R7: park pair0, pair2 takes over peripheral 5
    we = 1; wd = 16'hF53F; step("R6"); we = 0; step("R6"); step("R7");
    ak = 8'h10; step("R7"); ak = 8'h01; step("R6"); ak = '0; step("R6");

    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule